// File: doc/BRIEF.md
# Six-Bit Typewriter Output Decoder

This block sits between a processor's typewriter output command and an ASCII terminal sink. Each output command hands it a data word. The block keeps the low six bits as a typewriter code and turns that code into one 7-bit ASCII character on a valid/ready stream. The sink may stall the stream. Two of the six-bit codes do not print: they switch the block between a lower-case and an upper-case shift state. That state picks which half of the translation the following codes use. A carriage return is always followed on the stream by a line feed that the block generates itself.

When a character is finished, the block sets a done flag and pulses an interrupt request tagged with a priority level supplied from outside. If the command that loaded the character asked for a completion pulse, the block also pulses a restart strobe so a processor waiting on the command can resume. After reset the done flag reads as set, so the printer looks ready. A load that arrives while a character is still being handled is dropped.

Top module: `tw_out_decoder`

## Requirements
- R1: After reset, done_o is 1, out_valid_o, restart_o and irq_o are 0, and the shift state is lower case, so code 061 then prints 'a' (0x61).
- R2: A load accepted while idle clears done_o in the cycle that follows. Only load_data_i bits [5:0] form the code; the upper bits have no effect on the character sent.
- R3: Code 074 selects upper case and code 072 selects lower case. Neither code puts anything on the stream, and each still completes.
- R4: In lower case, codes 061..071 give 'a'..'i', 041..051 give 'j'..'r', 022..031 give 's'..'z', 001..011 give '1'..'9', and 020, 021, 033, 040, 054, 055, 056, 057, 073 give '0', '/', ',', '@', '-', ')', '\', '(', '.'.
- R5: In upper case the letter codes give capitals; 001..011 give '"', ''', '~', '#', '!', '&', '<', '>', '^'; and 020, 021, 033, 040, 054, 055, 056, 057, 073 give '`', '?', '=', '_', '+', ']', '|', '[', '*'.
- R6: In either case, code 077 gives carriage return (0x0D), 075 gives backspace (0x08), 036 gives tab (0x09) and 000 gives space (0x20).
- R7: Codes with no translation (for example 012 and 076) put nothing on the stream but still complete in the cycle after the load.
- R8: A carriage return is followed on the stream by a line feed (0x0A). The character completes only once the line feed is accepted.
- R9: While out_ready_i is low, out_valid_o stays high with out_data_o unchanged, and done_o stays low. Completion follows the cycle in which the sink accepts.
- R10: If load_cpls_i was high with the load, restart_o pulses high for one cycle together with completion; otherwise restart_o stays low.
- R11: On completion, done_o becomes 1 and irq_o pulses for one cycle. irq_lvl_o carries the value of prio_level_i sampled at that moment.
- R12: A load arriving while a character is still being handled is ignored: the pending character is sent unchanged, and no second character follows.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Output command strobe, one cycle |
| load_data_i | input | DATA_W | Data word; bits [5:0] are the code |
| load_cpls_i | input | 1 | Command requests a completion pulse |
| prio_level_i | input | LVL_W | Priority level attached to the interrupt |
| out_valid_o | output | 1 | ASCII character available |
| out_data_o | output | 7 | ASCII character |
| out_ready_i | input | 1 | Sink accepts the character |
| done_o | output | 1 | Done flag, printer ready |
| irq_o | output | 1 | Interrupt request pulse |
| irq_lvl_o | output | LVL_W | Level of the last interrupt |
| restart_o | output | 1 | Completion-pulse restart strobe |

## Verification
The bench walks both halves of the translation through shift codes placed in the stimulus, so a decoder that ignored the shift bit, or printed the shift codes, would send the wrong characters. It holds the sink stalled to catch a design that completes early or lets the character change under a stall. It also checks that a carriage return is followed by a line feed, and that completion waits until the line feed is accepted. Loads issued while busy and a reset taken while in upper case show whether the busy state or the case state leaks into the next character.

// File: rtl/tw_out_decoder.sv
module tw_out_decoder #(
  parameter int DATA_W = 18,
  parameter int LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              load_cpls_i,
  input  logic [LVL_W-1:0]  prio_level_i,
  output logic              out_valid_o,
  output logic [6:0]        out_data_o,
  input  logic              out_ready_i,
  output logic              done_o,
  output logic              irq_o,
  output logic [LVL_W-1:0]  irq_lvl_o,
  output logic              restart_o
);

  localparam logic [5:0] SHIFT_UP = 6'o74;
  localparam logic [5:0] SHIFT_DN = 6'o72;
  localparam logic [6:0] ASC_CR   = 7'h0D;
  localparam logic [6:0] ASC_LF   = 7'h0A;

  typedef enum logic [1:0] {ST_IDLE, ST_EMIT, ST_LF} st_t;

  st_t              state_q;
  logic [5:0]       code_q;
  logic             upper_q;
  logic             cpls_q;
  logic             done_q;
  logic             irq_q;
  logic             restart_q;
  logic [LVL_W-1:0] lvl_q;

  function automatic logic [6:0] xlate(input logic up, input logic [5:0] c);
    logic [6:0] ch;
    ch = 7'h00;
    if (c >= 6'o61 && c <= 6'o71)      ch = 7'h61 + 7'(c - 6'o61);
    else if (c >= 6'o41 && c <= 6'o51) ch = 7'h6A + 7'(c - 6'o41);
    else if (c >= 6'o22 && c <= 6'o31) ch = 7'h73 + 7'(c - 6'o22);
    if (ch != 7'h00) begin
      if (up) ch = ch - 7'h20;
    end else if (c >= 6'o01 && c <= 6'o11 && !up) begin
      ch = 7'h31 + 7'(c - 6'o01);
    end else begin
      case (c)
        6'o00: ch = 7'h20;
        6'o01: ch = 7'h22;
        6'o02: ch = 7'h27;
        6'o03: ch = 7'h7E;
        6'o04: ch = 7'h23;
        6'o05: ch = 7'h21;
        6'o06: ch = 7'h26;
        6'o07: ch = 7'h3C;
        6'o10: ch = 7'h3E;
        6'o11: ch = 7'h5E;
        6'o20: ch = up ? 7'h60 : 7'h30;
        6'o21: ch = up ? 7'h3F : 7'h2F;
        6'o33: ch = up ? 7'h3D : 7'h2C;
        6'o36: ch = 7'h09;
        6'o40: ch = up ? 7'h5F : 7'h40;
        6'o54: ch = up ? 7'h2B : 7'h2D;
        6'o55: ch = up ? 7'h5D : 7'h29;
        6'o56: ch = up ? 7'h7C : 7'h5C;
        6'o57: ch = up ? 7'h5B : 7'h28;
        6'o73: ch = up ? 7'h2A : 7'h2E;
        6'o75: ch = 7'h08;
        6'o77: ch = ASC_CR;
        default: ch = 7'h00;
      endcase
    end
    return ch;
  endfunction

  logic [6:0] ch;
  logic       is_shift;
  logic       emit_vis;
  logic       finish;

  assign ch       = xlate(upper_q, code_q);
  assign is_shift = (code_q == SHIFT_UP) || (code_q == SHIFT_DN);
  assign emit_vis = (state_q == ST_EMIT) && !is_shift && (ch != 7'h00);

  assign out_valid_o = emit_vis || (state_q == ST_LF);
  assign out_data_o  = (state_q == ST_LF) ? ASC_LF : (emit_vis ? ch : 7'h00);

  assign finish = ((state_q == ST_EMIT) && (!emit_vis || (out_ready_i && ch != ASC_CR))) ||
                  ((state_q == ST_LF) && out_ready_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      code_q    <= '0;
      upper_q   <= 1'b0;
      cpls_q    <= 1'b0;
      done_q    <= 1'b1;
      irq_q     <= 1'b0;
      restart_q <= 1'b0;
      lvl_q     <= '0;
    end else begin
      irq_q     <= 1'b0;
      restart_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (load_i) begin
          code_q  <= load_data_i[5:0];
          cpls_q  <= load_cpls_i;
          done_q  <= 1'b0;
          state_q <= ST_EMIT;
        end
        ST_EMIT: begin
          if (code_q == SHIFT_UP) upper_q <= 1'b1;
          if (code_q == SHIFT_DN) upper_q <= 1'b0;
          if (emit_vis && out_ready_i && ch == ASC_CR) state_q <= ST_LF;
        end
        default: ;
      endcase
      if (finish) begin
        state_q   <= ST_IDLE;
        done_q    <= 1'b1;
        irq_q     <= 1'b1;
        restart_q <= cpls_q;
        lvl_q     <= prio_level_i;
      end
    end
  end

  assign done_o    = done_q;
  assign irq_o     = irq_q;
  assign restart_o = restart_q;
  assign irq_lvl_o = lvl_q;

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  // R9
  busy_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> !done_o);

  // R8
  cr_then_lf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && out_data_o == ASC_CR) |=> (out_valid_o && out_data_o == ASC_LF));

  // R10
  restart_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |-> done_o);

  // R11
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R12
  busy_load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && load_i) |=> $stable(code_q));

endmodule

// File: tb/tw_out_decoder_tb.sv
module tw_out_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [17:0] ldata = '0;
  logic        lcpls = 1'b0;
  logic [3:0]  plev = 4'd0;
  logic        ovalid;
  logic [6:0]  odata;
  logic        oready = 1'b1;
  logic        done, irq, restart;
  logic [3:0]  ilvl;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  tw_out_decoder #(.DATA_W(18), .LVL_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_data_i(ldata),
    .load_cpls_i(lcpls), .prio_level_i(plev), .out_valid_o(ovalid),
    .out_data_o(odata), .out_ready_i(oready), .done_o(done), .irq_o(irq),
    .irq_lvl_o(ilvl), .restart_o(restart));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp<20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors + 0);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [17:0] d, input logic c);
    @(negedge clk);
    load = 1'b1; ldata = d; lcpls = c;
    @(negedge clk);
    load = 1'b0; lcpls = 1'b0;
  endtask

  // {code, expected char or 0 for none}
  localparam logic [13:0] VEC [26] = '{
    {6'o61, 8'h61}, {6'o01, 8'h31}, {6'o20, 8'h30}, {6'o54, 8'h2D},
    {6'o73, 8'h2E}, {6'o40, 8'h40}, {6'o22, 8'h73}, {6'o33, 8'h2C},
    {6'o12, 8'h00}, {6'o74, 8'h00}, {6'o61, 8'h41}, {6'o01, 8'h22},
    {6'o54, 8'h2B}, {6'o40, 8'h5F}, {6'o22, 8'h53}, {6'o33, 8'h3D},
    {6'o73, 8'h2A}, {6'o75, 8'h08}, {6'o36, 8'h09}, {6'o76, 8'h00},
    {6'o72, 8'h00}, {6'o51, 8'h72}, {6'o75, 8'h08}, {6'o36, 8'h09},
    {6'o56, 8'h5C}, {6'o11, 8'h39}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 done", done, 1);
    chk("R1 valid", ovalid, 0);
    chk("R1 irq", irq, 0);
    chk("R1 restart", restart, 0);

    plev = 4'd3;
    for (int i = 0; i < 26; i++) begin
      logic [5:0] c;
      logic [7:0] e;
      c = VEC[i][13:8];
      e = VEC[i][7:0];
      do_load({12'o0, c}, 1'b0);
      // R2 R3 R4 R5 R6 R7
      chk("R2 done cleared", done, 0);
      chk("R4/R5/R6 valid", ovalid, (e != 0) ? 1 : 0);
      if (e != 0) chk("R4/R5/R6 char", odata, e);
      @(negedge clk);
      chk("R11 done set", done, 1);
      chk("R11 irq", irq, 1);
      chk("R11 level", ilvl, 3);
      chk("R10 no restart", restart, 0);
      chk("R7/R3 quiet", ovalid, 0);
    end

    // R2 upper data bits ignored
    do_load(18'o777761, 1'b0);
    chk("R2 low bits", odata, 8'h61);
    @(negedge clk);

    // R8 carriage return then line feed
    do_load(18'o77, 1'b0);
    chk("R8 cr", odata, 8'h0D);
    @(negedge clk);
    chk("R8 lf valid", ovalid, 1);
    chk("R8 lf", odata, 8'h0A);
    chk("R8 not done", done, 0);
    @(negedge clk);
    chk("R8 done", done, 1);

    // R9 stall, R10 restart, R11 level
    plev = 4'd5;
    oready = 1'b0;
    do_load(18'o62, 1'b1);
    for (int k = 0; k < 3; k++) begin
      chk("R9 held valid", ovalid, 1);
      chk("R9 held data", odata, 8'h62);
      chk("R9 not done", done, 0);
      @(negedge clk);
    end
    oready = 1'b1;
    @(negedge clk);
    chk("R9 done", done, 1);
    chk("R10 restart", restart, 1);
    chk("R11 level 5", ilvl, 5);
    @(negedge clk);
    chk("R10 restart single", restart, 0);
    chk("R11 irq single", irq, 0);

    // R12 load while busy
    oready = 1'b0;
    do_load(18'o61, 1'b0);
    do_load(18'o62, 1'b0);
    chk("R12 pending kept", odata, 8'h61);
    oready = 1'b1;
    @(negedge clk);
    chk("R12 done", done, 1);
    for (int k = 0; k < 3; k++) begin
      chk("R12 no second char", ovalid, 0);
      @(negedge clk);
    end

    // R1 reset from upper case
    do_load(18'o74, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 done after reset", done, 1);
    do_load(18'o61, 1'b0);
    chk("R1 lower after reset", odata, 8'h61);
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule